// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a 512-byte data cache that sits between a processor's load/store port and a wide main memory. The processor offers one 32-bit word access at a time: a byte address, write data and a four-bit byte-enable. An all-zero byte-enable means the access is a load. The cache has eight lines of 64 bytes each. A separate tag array with a one-cycle read latency holds each line's tag. A data array of 128-bit rows holds the line data. Per-line valid and modified flags sit in flops, and reset clears them.

Each accepted access is compared against its line's stored tag one cycle after acceptance. A hit is answered in that same cycle. On a miss to a modified line, the old contents first go out to memory as one write request followed by four 128-bit data beats. One read request then brings the new line back in four response beats. After the refill the access is replayed, and the replay hits. Stores on a miss therefore land in the freshly filled line. Memory addresses count 128-bit units, so every line request is aligned to four units.

Top module: `wb_dcache`

## Requirements
- R1: After reset `cpu_req_ready` is 1, `cpu_resp_valid`, `mem_req_valid` and `mem_wdata_valid` are 0, and every line is invalid, so the first access to any address misses.
- R2: A byte address splits into byte offset [1:0], word lane within a 128-bit row [3:2], row within the line [5:4], line index [8:6] and tag [31:9]. Two addresses with the same index and different tags evict each other.
- R3: A hit accepted at a clock edge raises `cpu_resp_valid` for exactly the next cycle. For a load, `cpu_resp_data` then holds the stored word.
- R4: A nonzero byte-enable writes only the enabled bytes (bit n covers data bits 8n+7:8n) of the addressed word and marks the line modified. An all-zero byte-enable leaves the stored word unchanged and returns it.
- R5: A refill issues one memory request with `mem_req_rw`=0 and address `cpu_addr[31:6]` followed by two zero bits. It consumes four response beats, and beat k supplies words 4k..4k+3 of the line, with the lowest word in bits 31:0.
- R6: A miss to a valid modified line first issues a write request (`mem_req_rw`=1) at the old line's address. It then sends four data beats in row order 0..3 with `mem_wdata_mask` all ones, and only after that issues the refill request.
- R7: A miss to an invalid or unmodified line issues no write request.
- R8: After a refill the access completes as if it had hit. A load returns the word from memory, and a store merges its enabled bytes into the refilled word.
- R9: Once `mem_req_valid` is raised, it stays high with `mem_req_addr` and `mem_req_rw` unchanged until `mem_req_ready` is seen.
- R10: `cpu_req_ready` drops in the cycle after an access is accepted and stays low until the response. Each response is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor access offered |
| cpu_req_ready | output | 1 | Cache can take an access |
| cpu_req_addr | input | 32 | Byte address |
| cpu_req_data | input | 32 | Store data |
| cpu_req_wmask | input | 4 | Byte-enable, zero for a load |
| cpu_resp_valid | output | 1 | Access completed this cycle |
| cpu_resp_data | output | 32 | Load data |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_rw | output | 1 | 1 write-back, 0 refill |
| mem_req_addr | output | 28 | Address in 128-bit units |
| mem_wdata_valid | output | 1 | Write-back beat offered |
| mem_wdata_ready | input | 1 | Memory takes the beat |
| mem_wdata_bits | output | 128 | Write-back beat data |
| mem_wdata_mask | output | 16 | Byte-enable of the beat |
| mem_resp_valid | input | 1 | Refill beat present |
| mem_resp_data | input | 128 | Refill beat data |

## Verification
The bench builds the cache with its default geometry: eight 64-byte lines and a 128-bit memory port. Addresses are confined to a 2 KB window, which gives four tags per index. With only four competing tags, conflict misses, evictions of modified lines and replays of stores after a refill come up constantly in the random phase. A bench model of the line tags predicts each hit or miss, so the one-cycle hit latency is checked on every access. A memory model that logs requests and beats lets the directed cases confirm the write-back-then-refill order and the data carried in each beat.

// File: rtl/wb_dcache_pkg.sv
package wb_dcache_pkg;

    localparam int ADDR_W     = 32;
    localparam int WORD_W     = 32;
    localparam int MEM_W      = 128;
    localparam int LINE_W     = 512;
    localparam int NUM_LINES  = 8;

    localparam int WMASK_W    = WORD_W / 8;
    localparam int MMASK_W    = MEM_W / 8;
    localparam int BEATS      = LINE_W / MEM_W;
    localparam int LANES      = MEM_W / WORD_W;
    localparam int BOFF_W     = $clog2(WMASK_W);
    localparam int LANE_W     = $clog2(LANES);
    localparam int BEAT_W     = $clog2(BEATS);
    localparam int IDX_W      = $clog2(NUM_LINES);
    localparam int TAG_W      = ADDR_W - IDX_W - BEAT_W - LANE_W - BOFF_W;
    localparam int MEM_ADDR_W = ADDR_W - $clog2(MMASK_W);
    localparam int ROWS       = NUM_LINES * BEATS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WB_REQ,
        ST_WB_DATA,
        ST_RF_REQ,
        ST_RF_DATA,
        ST_REPLAY
    } cache_state_e;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [BEAT_W-1:0] row;
        logic [LANE_W-1:0] lane;
        logic [BOFF_W-1:0] boff;
    } cpu_addr_t;

    typedef struct packed {
        logic [TAG_W-1:0]  tag;
        logic [IDX_W-1:0]  idx;
        logic [BEAT_W-1:0] row;
        logic [LANE_W-1:0] lane;
        logic [WORD_W-1:0] data;
        logic [WMASK_W-1:0] wmask;
    } pend_req_t;

    function automatic logic [MEM_ADDR_W-1:0] line_unit_addr(
        input logic [TAG_W-1:0] tag,
        input logic [IDX_W-1:0] idx
    );
        return {tag, idx, {BEAT_W{1'b0}}};
    endfunction

    function automatic logic [MMASK_W-1:0] lane_byte_enable(
        input logic [WMASK_W-1:0] wmask,
        input logic [LANE_W-1:0]  lane
    );
        logic [MMASK_W-1:0] be;
        be = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane == LANE_W'(l)) be[l*WMASK_W +: WMASK_W] = wmask;
        end
        return be;
    endfunction

endpackage

// File: rtl/wb_dcache_sram.sv
module wb_dcache_sram #(
    parameter int DATA_W = 128,
    parameter int DEPTH  = 32,
    parameter int GRAN   = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int NB    = DATA_W / GRAN
) (
    input  logic              clk,
    input  logic              we,
    input  logic [NB-1:0]     be,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // single port: a write cycle leaves the read register holding its value
    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < NB; b++) begin
                if (be[b]) mem[addr][b*GRAN +: GRAN] <= wdata[b*GRAN +: GRAN];
            end
        end else begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/wb_dcache_line_state.sv
module wb_dcache_line_state
    import wb_dcache_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] idx,
    input  logic             fill_done,
    input  logic             mark_dirty,
    output logic             line_valid,
    output logic             line_dirty
);
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_done) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
endmodule

// File: rtl/wb_dcache_ctrl.sv
module wb_dcache_ctrl
    import wb_dcache_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_req_valid,
    output logic                  cpu_req_ready,
    input  logic [ADDR_W-1:0]     cpu_req_addr,
    input  logic [WORD_W-1:0]     cpu_req_data,
    input  logic [WMASK_W-1:0]    cpu_req_wmask,
    output logic                  cpu_resp_valid,
    output logic [WORD_W-1:0]     cpu_resp_data,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic                  mem_req_rw,
    output logic [MEM_ADDR_W-1:0] mem_req_addr,
    output logic                  mem_wdata_valid,
    input  logic                  mem_wdata_ready,
    output logic [MEM_W-1:0]      mem_wdata_bits,
    output logic [MMASK_W-1:0]    mem_wdata_mask,
    input  logic                  mem_resp_valid,
    input  logic [MEM_W-1:0]      mem_resp_data,
    output logic                  data_we,
    output logic [MMASK_W-1:0]    data_be,
    output logic [IDX_W+BEAT_W-1:0] data_addr,
    output logic [MEM_W-1:0]      data_wdata,
    input  logic [MEM_W-1:0]      data_rdata,
    output logic                  tag_we,
    output logic [IDX_W-1:0]      tag_addr,
    output logic [TAG_W-1:0]      tag_wdata,
    input  logic [TAG_W-1:0]      tag_rdata,
    output logic [IDX_W-1:0]      st_idx,
    output logic                  st_fill,
    output logic                  st_mark_dirty,
    input  logic                  line_valid,
    input  logic                  line_dirty
);
    cache_state_e      state_q, state_d;
    pend_req_t         req_q;
    logic [TAG_W-1:0]  victim_q;
    logic [BEAT_W-1:0] beat_q;
    logic              beat_ok_q;
    cpu_addr_t         in_addr;
    logic [IDX_W-1:0]  cur_idx;
    logic [BEAT_W-1:0] cur_row;
    logic              hit;
    logic              is_store;
    logic              last_beat;
    logic              unused_boff;

    assign in_addr     = cpu_addr_t'(cpu_req_addr);
    assign unused_boff = ^in_addr.boff;
    assign cur_idx     = (state_q == ST_IDLE) ? in_addr.idx : req_q.idx;
    assign cur_row     = (state_q == ST_IDLE) ? in_addr.row : req_q.row;
    assign hit         = line_valid && (tag_rdata == req_q.tag);
    assign is_store    = |req_q.wmask;
    assign last_beat   = (beat_q == BEAT_W'(BEATS - 1));
    assign st_idx      = cur_idx;

    assign cpu_resp_data  = data_rdata[req_q.lane*WORD_W +: WORD_W];
    assign mem_wdata_bits = data_rdata;
    assign mem_wdata_mask = '1;

    always_comb begin
        state_d         = state_q;
        cpu_req_ready   = 1'b0;
        cpu_resp_valid  = 1'b0;
        mem_req_valid   = 1'b0;
        mem_req_rw      = 1'b0;
        mem_req_addr    = line_unit_addr(req_q.tag, req_q.idx);
        mem_wdata_valid = 1'b0;
        data_we         = 1'b0;
        data_be         = '0;
        data_addr       = {cur_idx, cur_row};
        data_wdata      = {LANES{req_q.data}};
        tag_we          = 1'b0;
        tag_addr        = cur_idx;
        tag_wdata       = req_q.tag;
        st_fill         = 1'b0;
        st_mark_dirty   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cpu_req_ready = 1'b1;
                if (cpu_req_valid) state_d = ST_LOOKUP;
            end
            ST_LOOKUP: begin
                if (hit) begin
                    cpu_resp_valid = 1'b1;
                    state_d        = ST_IDLE;
                    if (is_store) begin
                        data_we       = 1'b1;
                        data_be       = lane_byte_enable(req_q.wmask, req_q.lane);
                        st_mark_dirty = 1'b1;
                    end
                end else if (line_valid && line_dirty) begin
                    state_d = ST_WB_REQ;
                end else begin
                    state_d = ST_RF_REQ;
                end
            end
            ST_WB_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_rw    = 1'b1;
                mem_req_addr  = line_unit_addr(victim_q, req_q.idx);
                data_addr     = {req_q.idx, {BEAT_W{1'b0}}};
                if (mem_req_ready) state_d = ST_WB_DATA;
            end
            ST_WB_DATA: begin
                data_addr       = {req_q.idx, beat_q};
                mem_wdata_valid = beat_ok_q;
                if (beat_ok_q && mem_wdata_ready && last_beat) state_d = ST_RF_REQ;
            end
            ST_RF_REQ: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) state_d = ST_RF_DATA;
            end
            ST_RF_DATA: begin
                data_addr = {req_q.idx, beat_q};
                if (mem_resp_valid) begin
                    data_we    = 1'b1;
                    data_be    = '1;
                    data_wdata = mem_resp_data;
                    if (last_beat) begin
                        tag_we  = 1'b1;
                        st_fill = 1'b1;
                        state_d = ST_REPLAY;
                    end
                end
            end
            ST_REPLAY: begin
                state_d = ST_LOOKUP;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            req_q     <= '0;
            victim_q  <= '0;
            beat_q    <= '0;
            beat_ok_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cpu_req_valid) begin
                req_q.tag   <= in_addr.tag;
                req_q.idx   <= in_addr.idx;
                req_q.row   <= in_addr.row;
                req_q.lane  <= in_addr.lane;
                req_q.data  <= cpu_req_data;
                req_q.wmask <= cpu_req_wmask;
            end
            if (state_q == ST_LOOKUP) begin
                victim_q <= tag_rdata;
                beat_q   <= '0;
            end
            if (state_q == ST_WB_REQ) beat_ok_q <= 1'b1;
            if (state_q == ST_WB_DATA) begin
                beat_ok_q <= !(beat_ok_q && mem_wdata_ready);
                if (beat_ok_q && mem_wdata_ready) beat_q <= beat_q + 1'b1;
            end
            if (state_q == ST_RF_DATA && mem_resp_valid) beat_q <= beat_q + 1'b1;
        end
    end
endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
    import wb_dcache_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cpu_req_valid,
    output logic                  cpu_req_ready,
    input  logic [ADDR_W-1:0]     cpu_req_addr,
    input  logic [WORD_W-1:0]     cpu_req_data,
    input  logic [WMASK_W-1:0]    cpu_req_wmask,
    output logic                  cpu_resp_valid,
    output logic [WORD_W-1:0]     cpu_resp_data,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic                  mem_req_rw,
    output logic [MEM_ADDR_W-1:0] mem_req_addr,
    output logic                  mem_wdata_valid,
    input  logic                  mem_wdata_ready,
    output logic [MEM_W-1:0]      mem_wdata_bits,
    output logic [MMASK_W-1:0]    mem_wdata_mask,
    input  logic                  mem_resp_valid,
    input  logic [MEM_W-1:0]      mem_resp_data
);
    logic                    data_we;
    logic [MMASK_W-1:0]      data_be;
    logic [IDX_W+BEAT_W-1:0] data_addr;
    logic [MEM_W-1:0]        data_wdata;
    logic [MEM_W-1:0]        data_rdata;
    logic                    tag_we;
    logic [IDX_W-1:0]        tag_addr;
    logic [TAG_W-1:0]        tag_wdata;
    logic [TAG_W-1:0]        tag_rdata;
    logic [IDX_W-1:0]        st_idx;
    logic                    st_fill;
    logic                    st_mark_dirty;
    logic                    line_valid;
    logic                    line_dirty;

    wb_dcache_ctrl i_ctrl (
        .clk, .rst,
        .cpu_req_valid, .cpu_req_ready, .cpu_req_addr, .cpu_req_data, .cpu_req_wmask,
        .cpu_resp_valid, .cpu_resp_data,
        .mem_req_valid, .mem_req_ready, .mem_req_rw, .mem_req_addr,
        .mem_wdata_valid, .mem_wdata_ready, .mem_wdata_bits, .mem_wdata_mask,
        .mem_resp_valid, .mem_resp_data,
        .data_we, .data_be, .data_addr, .data_wdata, .data_rdata,
        .tag_we, .tag_addr, .tag_wdata, .tag_rdata,
        .st_idx, .st_fill, .st_mark_dirty, .line_valid, .line_dirty
    );

    wb_dcache_sram #(.DATA_W(MEM_W), .DEPTH(ROWS), .GRAN(8)) i_data (
        .clk, .we(data_we), .be(data_be), .addr(data_addr),
        .wdata(data_wdata), .rdata(data_rdata)
    );

    wb_dcache_sram #(.DATA_W(TAG_W), .DEPTH(NUM_LINES), .GRAN(TAG_W)) i_tag (
        .clk, .we(tag_we), .be(1'b1), .addr(tag_addr),
        .wdata(tag_wdata), .rdata(tag_rdata)
    );

    wb_dcache_line_state i_state (
        .clk, .rst, .idx(st_idx), .fill_done(st_fill), .mark_dirty(st_mark_dirty),
        .line_valid, .line_dirty
    );
endmodule

// File: rtl/wb_dcache_chk.sv
module wb_dcache_chk
    import wb_dcache_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  cpu_req_valid,
    input logic                  cpu_req_ready,
    input logic                  cpu_resp_valid,
    input logic                  mem_req_valid,
    input logic                  mem_req_ready,
    input logic                  mem_req_rw,
    input logic [MEM_ADDR_W-1:0] mem_req_addr,
    input logic                  mem_wdata_valid,
    input logic [MMASK_W-1:0]    mem_wdata_mask
);
    // R1: while able to accept, the memory side is silent
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        cpu_req_ready |-> !mem_req_valid && !mem_wdata_valid);

    // R5: line requests are aligned to four 128-bit units
    p_line_aligned_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> mem_req_addr[BEAT_W-1:0] == '0);

    // R6: write-back beats carry a full byte mask
    p_full_mask_r6: assert property (@(posedge clk) disable iff (rst)
        mem_wdata_valid |-> &mem_wdata_mask);

    // R6: an accepted write request is followed by data, not another request
    p_wb_data_next_r6: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_ready && mem_req_rw |=> !mem_req_valid);

    // R9: request held until taken
    p_req_stable_r9: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=>
            mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_rw));

    // R10: single-cycle response
    p_resp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        cpu_resp_valid |=> !cpu_resp_valid);

    // R10: busy after acceptance
    p_busy_r10: assert property (@(posedge clk) disable iff (rst)
        cpu_req_valid && cpu_req_ready |=> !cpu_req_ready);
endmodule

bind wb_dcache wb_dcache_chk i_chk (.*);

// File: tb/test_wb_dcache.sv
module test_wb_dcache;
    localparam time HALF = 4ns;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cpu_req_valid = 1'b0;
    logic         cpu_req_ready;
    logic [31:0]  cpu_req_addr = '0;
    logic [31:0]  cpu_req_data = '0;
    logic [3:0]   cpu_req_wmask = '0;
    logic         cpu_resp_valid;
    logic [31:0]  cpu_resp_data;
    logic         mem_req_valid;
    logic         mem_req_ready = 1'b0;
    logic         mem_req_rw;
    logic [27:0]  mem_req_addr;
    logic         mem_wdata_valid;
    logic         mem_wdata_ready = 1'b0;
    logic [127:0] mem_wdata_bits;
    logic [15:0]  mem_wdata_mask;
    logic         mem_resp_valid = 1'b0;
    logic [127:0] mem_resp_data = '0;

    always #HALF clk = ~clk;

    wb_dcache i_wb_dcache (.*);

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [127:0] mem_model [128];
    logic [31:0]  ref_word  [512];
    logic [22:0]  mdl_tag   [8];
    bit           mdl_valid [8];
    bit           log_rw    [16];
    logic [27:0]  log_addr  [16];
    int           log_n = 0;
    logic [127:0] wb_beat   [4];
    bit           ready_while_busy;

    function automatic logic [31:0] seed_word(int i);
        return (i * 32'h9E3779B1) ^ 32'h5A17_C3E8;
    endfunction

    function automatic logic [31:0] merge(logic [31:0] old_w, logic [31:0] new_w, logic [3:0] m);
        logic [31:0] r = old_w;
        for (int b = 0; b < 4; b++) if (m[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
        return r;
    endfunction

    task automatic check(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // memory side responder
    initial begin
        for (int u = 0; u < 128; u++)
            mem_model[u] = {seed_word(4*u+3), seed_word(4*u+2), seed_word(4*u+1), seed_word(4*u)};
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                automatic logic [27:0] a0 = mem_req_addr;
                automatic bit          w0 = mem_req_rw;
                repeat ($urandom_range(0, 2)) begin
                    @(negedge clk);
                    check(mem_req_valid && mem_req_addr == a0 && mem_req_rw == w0,
                          "R9 request held", {99'b0, mem_req_rw, mem_req_addr}, {99'b0, w0, a0});
                end
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                if (log_n < 16) begin
                    log_rw[log_n] = w0;
                    log_addr[log_n] = a0;
                    log_n++;
                end
                if (w0) begin
                    for (int k = 0; k < 4; k++) begin
                        while (!mem_wdata_valid) @(negedge clk);
                        check(mem_wdata_mask == 16'hFFFF, "R6 beat mask", {112'b0, mem_wdata_mask}, 128'hFFFF);
                        mem_model[{a0[6:2], 2'(k)}] = mem_wdata_bits;
                        wb_beat[k] = mem_wdata_bits;
                        mem_wdata_ready = 1'b1;
                        @(negedge clk);
                        mem_wdata_ready = 1'b0;
                    end
                end else begin
                    for (int k = 0; k < 4; k++) begin
                        repeat ($urandom_range(0, 1)) @(negedge clk);
                        mem_resp_valid = 1'b1;
                        mem_resp_data  = mem_model[{a0[6:2], 2'(k)}];
                        @(negedge clk);
                        mem_resp_valid = 1'b0;
                    end
                end
            end
        end
    end

    // one processor access, called at a falling edge; also updates the bench model
    task automatic cpu_op(input logic [31:0] addr, input logic [31:0] data, input logic [3:0] m,
                          output logic [31:0] rd, output int lat, output bit exp_hit, output logic [31:0] exp_rd);
        automatic int          wi  = int'(addr[10:2]);
        automatic logic [2:0]  idx = addr[8:6];
        exp_hit = mdl_valid[idx] && mdl_tag[idx] == addr[31:9];
        exp_rd  = ref_word[wi];
        cpu_req_valid = 1'b1;
        cpu_req_addr  = addr;
        cpu_req_data  = data;
        cpu_req_wmask = m;
        while (!cpu_req_ready) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        lat = 0;
        ready_while_busy = 0;
        while (!cpu_resp_valid) begin
            if (cpu_req_ready) ready_while_busy = 1;
            @(negedge clk);
            lat++;
        end
        rd = cpu_resp_data;
        @(negedge clk);
        ref_word[wi]   = merge(ref_word[wi], data, m);
        mdl_valid[idx] = 1;
        mdl_tag[idx]   = addr[31:9];
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        logic [31:0] rd, er, mw;
        int          lat;
        bit          eh;
        for (int i = 0; i < 512; i++) ref_word[i] = seed_word(i);
        for (int i = 0; i < 8; i++) mdl_valid[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(cpu_req_ready == 1 && cpu_resp_valid == 0 && mem_req_valid == 0 && mem_wdata_valid == 0,
              "R1 reset outputs", {cpu_req_ready, cpu_resp_valid, mem_req_valid, mem_wdata_valid}, 4'b1000);

        // R5 / R7 / R1: first access is a clean miss
        log_n = 0;
        cpu_op(32'h40, 0, 4'b0000, rd, lat, eh, er);
        check(lat > 0, "R1 first access misses", lat, 1);
        check(log_n == 1 && log_rw[0] == 0 && log_addr[0] == 28'h4, "R5 refill request",
              {log_n[7:0], 7'b0, log_rw[0], log_addr[0]}, {8'd1, 8'd0, 28'h4});
        check(rd == er, "R8 refilled load data", rd, er);
        check(!ready_while_busy, "R10 ready low during miss", 1, 0);

        // R3 / R2: hit on another lane and row of the same line
        cpu_op(32'h7C, 0, 4'b0000, rd, lat, eh, er);
        check(lat == 0, "R3 hit latency", lat, 0);
        check(rd == er, "R3 hit data", rd, er);

        // R4 partial store then load
        cpu_op(32'h44, 32'hDEADBEEF, 4'b0101, rd, lat, eh, er);
        mw = merge(er, 32'hDEADBEEF, 4'b0101);
        cpu_op(32'h44, 0, 4'b0000, rd, lat, eh, er);
        check(rd == mw, "R4 masked store merge", rd, mw);
        cpu_op(32'h44, 32'hFFFFFFFF, 4'b0000, rd, lat, eh, er);
        check(rd == mw, "R4 zero mask returns word", rd, mw);
        cpu_op(32'h44, 0, 4'b0000, rd, lat, eh, er);
        check(rd == mw, "R4 zero mask writes nothing", rd, mw);

        // R6 / R2: conflict on index 1 evicts the modified line first
        log_n = 0;
        cpu_op(32'h240, 0, 4'b0000, rd, lat, eh, er);
        check(log_n == 2 && log_rw[0] == 1 && log_addr[0] == 28'h4, "R6 write-back first",
              {log_n[7:0], 7'b0, log_rw[0], log_addr[0]}, {8'd2, 8'd1, 28'h4});
        check(log_rw[1] == 0 && log_addr[1] == 28'h24, "R6 refill after write-back",
              {log_rw[1], log_addr[1]}, {1'b0, 28'h24});
        check(wb_beat[0][63:32] == mw, "R6 beat 0 lane 1 data", wb_beat[0][63:32], mw);
        check(wb_beat[3][127:96] == ref_word[31], "R6 beat 3 lane 3 data", wb_beat[3][127:96], ref_word[31]);
        check(rd == er, "R8 load after eviction", rd, er);

        // R7: the refilled line is clean, so going back needs no write-back
        log_n = 0;
        cpu_op(32'h44, 0, 4'b0000, rd, lat, eh, er);
        check(log_n == 1 && log_rw[0] == 0, "R7 no write-back on clean miss",
              {log_n[7:0], 7'b0, log_rw[0]}, {8'd1, 8'd0});
        check(rd == mw, "R6 written-back word survives", rd, mw);

        // R8: store miss merges into refilled line
        cpu_op(32'h300, 32'h0BADF00D, 4'b1111, rd, lat, eh, er);
        check(lat > 0, "R8 store miss refills", lat, 1);
        cpu_op(32'h300, 0, 4'b0000, rd, lat, eh, er);
        check(rd == 32'h0BADF00D && lat == 0, "R8 store after refill", rd, 32'h0BADF00D);
        cpu_op(32'h304, 0, 4'b0000, rd, lat, eh, er);
        check(rd == er, "R5 neighbour word of refill", rd, er);

        // random mix within a 2 KB window (four tags per index)
        for (int n = 0; n < 2500; n++) begin
            automatic logic [31:0] a = {21'b0, 9'($urandom_range(0, 511)), 2'b00};
            automatic logic [3:0]  m = ($urandom_range(0, 1) == 0) ? 4'b0000 : 4'($urandom);
            automatic logic [31:0] d = $urandom;
            cpu_op(a, d, m, rd, lat, eh, er);
            check((lat == 0) == eh, "R3 hit or miss as predicted", lat, {127'b0, !eh});
            if (m == 4'b0000) check(rd == er, "R4 random load", rd, er);
        end
        finish_run();
    end
endmodule